// File: doc/BRIEF.md
# Cascaded Vectored Priority Interrupt Controller

This block collects interrupt requests from peripherals and presents them to a processor as one interrupt line plus a vector. Two identical eight-line priority units are built in: a master, which talks to the processor, and a slave, whose own interrupt request stands in for one of the master's lines. Fifteen request lines reach the processor this way. Each unit latches new requests, removes masked ones, picks the most urgent, and keeps a record of which levels are being serviced. A request is only raised when it outranks every level already in service, so handlers nest strictly by priority.

When the processor acknowledges, the winning request moves from pending to in service and an 8-bit vector is presented for one cycle. If the master's winner is its cascade line, the slave resolves the acknowledge and supplies the vector. Software ends a handler with an end-of-interrupt command aimed at one unit. A source routed through the cascade therefore needs one command for the slave and one for the master.

Top module: `irq_cascade_ctl`

## Requirements
- R1: Synchronous reset clears pending, in-service and mask state, sets both vector bases to 0, and drives `int_o` and `vec_oe_o` low.
- R2: A request is latched as pending on a 0-to-1 change of its `req_i` bit. A line held high after being serviced does not request again.
- R3: Priority is fixed, with line 0 highest and line 7 lowest. A master source on line n produces the vector {master base, n}, with the base in bits 7:3 and n in bits 2:0.
- R4: A mask bit of 1 keeps that line's pending request out of arbitration. The request stays pending and competes once the mask bit returns to 0.
- R5: `int_o` is the registered interrupt decision. In the cycle after an `ack_i` cycle in which a request was eligible, `vec_oe_o` is high for one cycle with the vector, and the winner moves from pending to in service.
- R6: A request is eligible only if it outranks the highest-priority in-service level of its unit. Equal-priority or lower-priority requests wait.
- R7: `eoi_i` clears the highest-priority in-service bit of the unit chosen by `eoi_sel_i` (0 selects the master, 1 the slave).
- R8: Slave sources are `req_i[15:8]` (slave line k is `req_i[8+k]`). They compete at master line 2, which tracks the slave's request level, and they use the vector {slave base, k}. `req_i[2]` has no effect.
- R9: Slave line 1 (`req_i[9]`) is reported with the vector {master base, 3'd2}.
- R10: An `ack_i` when no request is eligible produces no vector and changes no state.
- R11: When `ack_i` and `eoi_i` reach the same unit in the same cycle, the end-of-interrupt clears the in-service level that existed before the cycle. The newly acknowledged level stays in service.
- R12: `cfg_we_i` writes `cfg_mask_i` and `cfg_base_i` into the unit chosen by `cfg_sel_i` (0 selects the master, 1 the slave). The new values take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 16 | Request lines: [7:0] master (bit 2 unused), [15:8] slave |
| ack_i | input | 1 | Processor acknowledge, one cycle |
| eoi_i | input | 1 | End-of-interrupt command |
| eoi_sel_i | input | 1 | End-of-interrupt target: 0 master, 1 slave |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | Configuration target: 0 master, 1 slave |
| cfg_mask_i | input | 8 | Mask value, 1 blocks a line |
| cfg_base_i | input | 5 | Vector base value |
| int_o | output | 1 | Interrupt request to the processor |
| vec_oe_o | output | 1 | Vector valid on `vec_o` |
| vec_o | output | 8 | Vector data |

## Verification
Two pairs of functions can land in the same cycle. The first pair is an acknowledge and an end-of-interrupt aimed at the same unit. The bench provokes this by acknowledging a preempting line while a lower one is in service and issuing the end-of-interrupt in that same cycle. It then judges the outcome by whether a later, lower-priority request is still held back. The second pair is a new rising edge and a pending bit being cleared by acknowledge. This case and the rest are compared every cycle against a behavioural model of pending, in-service and mask state.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IRQ_N       = 8;
  localparam int VEC_W       = 8;
  localparam int LINE_W      = $clog2(IRQ_N);
  localparam int BASE_W      = VEC_W - LINE_W;
  localparam int CASC_LINE   = 2;
  localparam int COMPAT_LINE = 1;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  bits_i,
  output logic          any_o,
  output logic [LW-1:0] idx_o
);
  always_comb begin
    any_o = |bits_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits_i[i]) idx_o = LW'(i);
    end
  end
endmodule

// File: rtl/irq_unit.sv
module irq_unit #(
  parameter int           N           = irq_pkg::IRQ_N,
  parameter int           BW          = irq_pkg::BASE_W,
  parameter logic [N-1:0] LEVEL_LINES = '0,
  localparam int          LW          = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_i,
  input  logic          cfg_we_i,
  input  logic [N-1:0]  cfg_mask_i,
  input  logic [BW-1:0] cfg_base_i,
  input  logic          ack_i,
  input  logic          eoi_i,
  output logic          int_req_o,
  output logic [LW-1:0] win_o,
  output logic [BW-1:0] base_o
);
  logic [N-1:0]  req_q, pend_q, isr_q, mask_q;
  logic [BW-1:0] base_q;
  logic [N-1:0]  pend_eff, rise, cand, take_vec, eoi_vec;
  logic          cand_any, isr_any, take;
  logic [LW-1:0] isr_top;

  for (genvar g = 0; g < N; g++) begin : g_line
    if (LEVEL_LINES[g]) begin : g_lvl
      assign pend_eff[g] = req_i[g];
      assign rise[g]     = 1'b0;
    end else begin : g_edge
      assign pend_eff[g] = pend_q[g];
      assign rise[g]     = req_i[g] & ~req_q[g];
    end
  end

  assign cand = pend_eff & ~mask_q;

  irq_prio_enc #(.N(N)) u_win (.bits_i(cand),  .any_o(cand_any), .idx_o(win_o));
  irq_prio_enc #(.N(N)) u_isr (.bits_i(isr_q), .any_o(isr_any),  .idx_o(isr_top));

  assign int_req_o = cand_any && (!isr_any || (win_o < isr_top));
  assign take      = ack_i && int_req_o;
  assign take_vec  = take ? (N'(1) << win_o) : '0;
  assign eoi_vec   = (eoi_i && isr_any) ? (N'(1) << isr_top) : '0;
  assign base_o    = base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      pend_q <= '0;
      isr_q  <= '0;
      mask_q <= '0;
      base_q <= '0;
    end else begin
      req_q  <= req_i;
      pend_q <= (pend_q & ~take_vec) | rise;
      isr_q  <= (isr_q & ~eoi_vec) | take_vec;
      if (cfg_we_i) begin
        mask_q <= cfg_mask_i;
        base_q <= cfg_base_i;
      end
    end
  end

  a_r5_ack_sets_service: assert property (@(posedge clk) disable iff (rst)
    (ack_i && int_req_o) |=> isr_q[$past(win_o)]);

  a_r4_masked_never_wins: assert property (@(posedge clk) disable iff (rst)
    int_req_o |-> !mask_q[win_o]);

  a_r7_eoi_drops_one: assert property (@(posedge clk) disable iff (rst)
    (eoi_i && !take && isr_q != '0) |=>
      ($countones(isr_q) == $past($countones(isr_q)) - 1));
endmodule

// File: rtl/irq_cascade_ctl.sv
module irq_cascade_ctl
  import irq_pkg::*;
#(
  parameter int  N  = IRQ_N,
  localparam int LW = $clog2(N),
  localparam int BW = VEC_W - LW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2*N-1:0]   req_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  input  logic             eoi_sel_i,
  input  logic             cfg_we_i,
  input  logic             cfg_sel_i,
  input  logic [N-1:0]     cfg_mask_i,
  input  logic [BW-1:0]    cfg_base_i,
  output logic             int_o,
  output logic             vec_oe_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam logic [N-1:0]  M_LEVEL = N'(1) << CASC_LINE;
  localparam logic [LW-1:0] CASC    = LW'(CASC_LINE);
  localparam logic [LW-1:0] COMPAT  = LW'(COMPAT_LINE);

  logic [N-1:0]  m_lines;
  logic          m_int, s_int, s_ack;
  logic [LW-1:0] m_win, s_win;
  logic [BW-1:0] m_base, s_base;

  always_comb begin
    m_lines       = req_i[N-1:0];
    m_lines[CASC] = s_int;
  end

  assign s_ack = ack_i && m_int && (m_win == CASC);

  irq_unit #(.N(N), .BW(BW), .LEVEL_LINES(M_LEVEL)) u_master (
    .clk(clk), .rst(rst), .req_i(m_lines),
    .cfg_we_i(cfg_we_i && !cfg_sel_i), .cfg_mask_i(cfg_mask_i), .cfg_base_i(cfg_base_i),
    .ack_i(ack_i), .eoi_i(eoi_i && !eoi_sel_i),
    .int_req_o(m_int), .win_o(m_win), .base_o(m_base));

  irq_unit #(.N(N), .BW(BW), .LEVEL_LINES('0)) u_slave (
    .clk(clk), .rst(rst), .req_i(req_i[2*N-1:N]),
    .cfg_we_i(cfg_we_i && cfg_sel_i), .cfg_mask_i(cfg_mask_i), .cfg_base_i(cfg_base_i),
    .ack_i(s_ack), .eoi_i(eoi_i && eoi_sel_i),
    .int_req_o(s_int), .win_o(s_win), .base_o(s_base));

  always_ff @(posedge clk) begin
    if (rst) begin
      int_o    <= 1'b0;
      vec_oe_o <= 1'b0;
      vec_o    <= '0;
    end else begin
      int_o    <= m_int;
      vec_oe_o <= ack_i && m_int;
      if (ack_i && m_int) begin
        if (m_win != CASC)        vec_o <= {m_base, m_win};
        else if (s_win == COMPAT) vec_o <= {m_base, CASC};
        else                      vec_o <= {s_base, s_win};
      end
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!int_o && !vec_oe_o));

  a_r5_vector_follows_ack: assert property (@(posedge clk) disable iff (rst)
    vec_oe_o |-> $past(ack_i));

  a_r8_slave_ack_needs_slave: assert property (@(posedge clk) disable iff (rst)
    s_ack |-> s_int);
endmodule

// File: tb/irq_cascade_ctl_tb.sv
module irq_cascade_ctl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] req = '0;
  logic        ack = 1'b0, eoi = 1'b0, eoi_sel = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0]  cfg_mask = '0;
  logic [4:0]  cfg_base = '0;
  logic        int_o, vec_oe_o;
  logic [7:0]  vec_o;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  string phase = "R1";

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_cascade_ctl u_dut (
    .clk(clk), .rst(rst), .req_i(req), .ack_i(ack), .eoi_i(eoi), .eoi_sel_i(eoi_sel),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_mask_i(cfg_mask), .cfg_base_i(cfg_base),
    .int_o(int_o), .vec_oe_o(vec_oe_o), .vec_o(vec_o));

  // behavioural reference model
  logic [7:0] m_prev, s_prev, m_pend, s_pend, m_isr, s_isr, m_mask, s_mask;
  logic [4:0] m_base, s_base;
  logic       e_int, e_oe;
  logic [7:0] e_vec;

  function automatic int lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  always @(posedge clk) begin : model
    int sw, st, mw, mt;
    bit sreq, mreq;
    logic [7:0] meff, nmi, nsi, nmp, nsp;
    if (rst) begin
      m_prev = '0; s_prev = '0; m_pend = '0; s_pend = '0;
      m_isr = '0; s_isr = '0; m_mask = '0; s_mask = '0;
      m_base = '0; s_base = '0; e_int = 0; e_oe = 0; e_vec = '0;
    end else begin
      sw = lowest(s_pend & ~s_mask);
      st = lowest(s_isr);
      sreq = (sw < 8) && (sw < st);
      meff = m_pend;
      meff[2] = sreq;
      mw = lowest(meff & ~m_mask);
      mt = lowest(m_isr);
      mreq = (mw < 8) && (mw < mt);
      nmi = m_isr; nsi = s_isr; nmp = m_pend; nsp = s_pend;
      e_int = mreq;
      e_oe = 0;
      if (eoi && !eoi_sel && mt < 8) nmi[mt] = 1'b0;
      if (eoi && eoi_sel && st < 8)  nsi[st] = 1'b0;
      if (ack && mreq) begin
        e_oe = 1;
        nmi[mw] = 1'b1;
        if (mw != 2) begin
          nmp[mw] = 1'b0;
          e_vec = {m_base, 3'(mw)};
        end else begin
          nsi[sw] = 1'b1;
          nsp[sw] = 1'b0;
          e_vec = (sw == 1) ? {m_base, 3'd2} : {s_base, 3'(sw)};
        end
      end
      for (int i = 0; i < 8; i++) begin
        if (i != 2 && req[i] && !m_prev[i]) nmp[i] = 1'b1;
        if (req[8+i] && !s_prev[i]) nsp[i] = 1'b1;
      end
      m_prev = req[7:0];
      s_prev = req[15:8];
      m_isr = nmi; s_isr = nsi; m_pend = nmp; s_pend = nsp;
      if (cfg_we && !cfg_sel) begin m_mask = cfg_mask; m_base = cfg_base; end
      if (cfg_we && cfg_sel)  begin s_mask = cfg_mask; s_base = cfg_base; end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (int_o !== e_int) begin
        errors++;
        $display("FAIL %s: int_o got %0b exp %0b", phase, int_o, e_int);
      end
      checks++;
      if (vec_oe_o !== e_oe) begin
        errors++;
        $display("FAIL %s: vec_oe_o got %0b exp %0b", phase, vec_oe_o, e_oe);
      end
      if (e_oe) begin
        checks++;
        if (vec_o !== e_vec) begin
          errors++;
          $display("FAIL %s: vec_o got %h exp %h", phase, vec_o, e_vec);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog: cycles got %0d exp below 50000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic cfg(input bit sel, input logic [7:0] mask, input logic [4:0] base);
    cfg_we = 1; cfg_sel = sel; cfg_mask = mask; cfg_base = base;
    step(1);
    cfg_we = 0;
  endtask

  task automatic pulse(input logic [15:0] bits);
    req = req | bits;
    step(2);
    req = req & ~bits;
  endtask

  task automatic end_int(input bit sel);
    eoi = 1; eoi_sel = sel;
    step(1);
    eoi = 0;
  endtask

  task automatic take(input logic [7:0] expv, input string tag, input bit with_eoi, input bit eoi_target);
    int n = 0;
    while (!int_o && n < 50) begin step(1); n++; end
    checks++;
    if (!int_o) begin
      errors++;
      $display("FAIL %s: int_o got 0 exp 1", tag);
    end
    ack = 1;
    if (with_eoi) begin eoi = 1; eoi_sel = eoi_target; end
    step(1);
    ack = 0; eoi = 0;
    check(tag, {7'd0, vec_oe_o}, 8'd1);
    check(tag, vec_o, expv);
  endtask

  initial begin
    step(3);
    rst = 0;
    step(1);
    phase = "R1";
    check("R1", {6'd0, int_o, vec_oe_o}, 8'd0);
    step(2);

    phase = "R12";
    cfg(0, 8'h00, 5'h04);
    cfg(1, 8'h00, 5'h09);
    pulse(16'h0008);
    take(8'h23, "R12", 0, 0);
    end_int(0);

    phase = "R3";
    pulse(16'h0028);
    take(8'h23, "R3", 0, 0);
    end_int(0);
    take(8'h25, "R3", 0, 0);
    end_int(0);

    phase = "R2";
    req[6] = 1;
    take(8'h26, "R2", 0, 0);
    end_int(0);
    step(4);
    check("R2", {7'd0, int_o}, 8'd0);
    req[6] = 0;
    step(1);

    phase = "R4";
    cfg(0, 8'h01, 5'h04);
    pulse(16'h0041);
    take(8'h26, "R4", 0, 0);
    step(3);
    check("R4", {7'd0, int_o}, 8'd0);
    cfg(0, 8'h00, 5'h04);
    take(8'h20, "R4", 0, 0);
    end_int(0);
    end_int(0);

    phase = "R6";
    pulse(16'h0010);
    take(8'h24, "R6", 0, 0);
    pulse(16'h0040);
    step(3);
    check("R6", {7'd0, int_o}, 8'd0);
    pulse(16'h0002);
    take(8'h21, "R6", 0, 0);
    end_int(0);
    step(3);
    check("R6", {7'd0, int_o}, 8'd0);
    end_int(0);
    take(8'h26, "R6", 0, 0);
    end_int(0);

    phase = "R8";
    pulse(16'h0004);
    step(3);
    check("R8", {7'd0, int_o}, 8'd0);
    pulse(16'h2008);
    take(8'h4D, "R8", 0, 0);
    step(3);
    check("R8", {7'd0, int_o}, 8'd0);
    end_int(1);
    end_int(0);
    take(8'h23, "R8", 0, 0);
    end_int(0);

    phase = "R9";
    pulse(16'h0200);
    take(8'h22, "R9", 0, 0);
    end_int(1);
    end_int(0);

    phase = "R10";
    step(3);
    ack = 1;
    step(1);
    ack = 0;
    check("R10", {7'd0, vec_oe_o}, 8'd0);
    step(2);
    check("R10", {7'd0, int_o}, 8'd0);

    phase = "R11";
    pulse(16'h0020);
    take(8'h25, "R11", 0, 0);
    pulse(16'h0002);
    take(8'h21, "R11", 1, 0);
    pulse(16'h0008);
    step(3);
    check("R11", {7'd0, int_o}, 8'd0);
    end_int(0);
    take(8'h23, "R11", 0, 0);
    end_int(0);

    phase = "R5";
    step(3);
    check("R5", {6'd0, int_o, vec_oe_o}, 8'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule